// File: doc/BRIEF.md
# Read-Sequence Command Detector

This block watches the access strobes of a memory bus and recognises two commands that software encodes as a chain of six read cycles to fixed addresses. The first five addresses form a shared key prefix. The address of the sixth read selects the command: one value requests a save of the array contents, and the other requests a reload. When a command is recognised, the block emits a one-cycle pulse on the matching output. It also raises an I/O-disable flag, which stays high until the downstream engine reports completion on `done`.

Only read cycles can move the sequence forward. A read strobe counts whether or not the output driver is enabled, so the block has no output-enable input. A write, or a read of any address other than the next expected one, discards the progress made so far. As a special case, a stray read of the first key address is taken as a fresh first step. While the flag is high, every bus access is ignored.

Top module: `seqcmd_detect`

## Requirements
- R1: After reset, `store_cmd`, `recall_cmd` and `io_dis` are low and no key step is pending.
- R2: Reads of 0x4E38, 0xB1C7, 0x83E0, 0x7C1F, 0x703F and then 0x8FC0, in that order, produce `store_cmd` high for exactly the one cycle after the clock edge that accepts the sixth read. `recall_cmd` stays low.
- R3: The same five-read prefix followed by a read of 0x4C63 produces a one-cycle `recall_cmd` pulse with the same timing. `store_cmd` stays low.
- R4: A read of an address that is not the next expected key aborts the sequence. Completing the remaining steps afterwards issues no command.
- R5: Any cycle with `wr_vld` high aborts the sequence, even when the address written is the next expected key. If `rd_vld` and `wr_vld` are both high, the cycle counts as a write.
- R6: Cycles with both strobes low, whatever the address, neither advance nor abort the sequence.
- R7: A non-matching read of 0x4E38 restarts the sequence at step one rather than at zero.
- R8: `io_dis` rises in the same cycle as the command pulse. It stays high until `done` is sampled high, and it is low in the cycle after that edge.
- R9: While `io_dis` is high, reads and writes are ignored. Key reads made during that time do not count toward a later sequence.
- R10: At the sixth step, a read of any address other than 0x8FC0 or 0x4C63 issues no command and aborts the sequence. The exception is 0x4E38, which follows R7.
- R11: A `done` pulse while `io_dis` is low has no effect on the outputs or on a sequence in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Address of the current bus access |
| rd_vld | input | 1 | A valid read cycle is taking place this clock |
| wr_vld | input | 1 | A valid write cycle is taking place this clock |
| done | input | 1 | The issued command has completed |
| store_cmd | output | 1 | One-cycle save request |
| recall_cmd | output | 1 | One-cycle reload request |
| io_dis | output | 1 | Bus I/O is disabled while a command runs |

## Verification
The bench builds the block with its default `ADDR_W` of 16, so every key value fills the address bus exactly and no upper bits need masking. At that width the bench can drive every key address as is, along with near-miss values and the store and recall codes at each of the six steps. This brings aborts, restarts, idle gaps and the final-step choice within reach at every position in the chain.

// File: rtl/seqcmd_pkg.sv
package seqcmd_pkg;
  localparam int KEY_W      = 16;
  localparam int PREFIX_LEN = 5;
  localparam logic [KEY_W-1:0] STORE_KEY  = 16'h8FC0;
  localparam logic [KEY_W-1:0] RECALL_KEY = 16'h4C63;

  // Address expected at prefix position idx (0-based).
  function automatic logic [KEY_W-1:0] prefix_key(input int idx);
    case (idx)
      0:       return 16'h4E38;
      1:       return 16'hB1C7;
      2:       return 16'h83E0;
      3:       return 16'h7C1F;
      4:       return 16'h703F;
      default: return 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/seqcmd_match.sv
module seqcmd_match #(
  parameter int ADDR_W = 16,
  parameter int STEP_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [STEP_W-1:0] step,
  output logic              hit_next,
  output logic              hit_first,
  output logic              hit_store,
  output logic              hit_recall
);
  import seqcmd_pkg::*;

  logic [PREFIX_LEN-1:0] eq_vec;

  generate
    for (genvar i = 0; i < PREFIX_LEN; i++) begin : g_cmp
      assign eq_vec[i] = (addr == ADDR_W'(prefix_key(i)));
    end
  endgenerate

  always_comb begin
    hit_next = 1'b0;
    for (int i = 0; i < PREFIX_LEN; i++) begin
      if (step == STEP_W'(i)) hit_next = eq_vec[i];
    end
  end

  assign hit_first  = eq_vec[0];
  assign hit_store  = (addr == ADDR_W'(STORE_KEY));
  assign hit_recall = (addr == ADDR_W'(RECALL_KEY));
endmodule

// File: rtl/seqcmd_step.sv
module seqcmd_step #(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              restart,
  input  logic              advance,
  output logic [STEP_W-1:0] step_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       step_q <= '0;
    else if (clear)   step_q <= '0;
    else if (restart) step_q <= STEP_W'(1);
    else if (advance) step_q <= step_q + STEP_W'(1);
  end
endmodule

// File: rtl/seqcmd_lock.sv
module seqcmd_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_store,
  input  logic fire_recall,
  input  logic done,
  output logic store_cmd,
  output logic recall_cmd,
  output logic busy
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store_cmd  <= 1'b0;
      recall_cmd <= 1'b0;
      busy       <= 1'b0;
    end else begin
      store_cmd  <= fire_store;
      recall_cmd <= fire_recall;
      if (fire_store || fire_recall) busy <= 1'b1;
      else if (done)                 busy <= 1'b0;
    end
  end
endmodule

// File: rtl/seqcmd_detect.sv
module seqcmd_detect #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_vld,
  input  logic              wr_vld,
  input  logic              done,
  output logic              store_cmd,
  output logic              recall_cmd,
  output logic              io_dis
);
  import seqcmd_pkg::*;

  localparam int STEP_W = $clog2(PREFIX_LEN + 1);

  logic [STEP_W-1:0] step_q;
  logic hit_next, hit_first, hit_store, hit_recall;
  logic at_final, rd_acc, wr_abort;
  logic advance, restart, clear, fire_store, fire_recall;

  seqcmd_match #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_match (
    .addr(addr), .step(step_q), .hit_next(hit_next), .hit_first(hit_first),
    .hit_store(hit_store), .hit_recall(hit_recall)
  );

  // Named events used by the datapath and by the bound checker.
  assign at_final    = (step_q == STEP_W'(PREFIX_LEN));
  assign wr_abort    = !io_dis && wr_vld;
  assign rd_acc      = !io_dis && rd_vld && !wr_vld;
  assign fire_store  = rd_acc && at_final && hit_store;
  assign fire_recall = rd_acc && at_final && hit_recall;
  assign advance     = rd_acc && !at_final && hit_next;
  assign restart     = rd_acc && !advance && !fire_store && !fire_recall && hit_first;
  assign clear       = wr_abort || (rd_acc && !advance && !restart);

  seqcmd_step #(.STEP_W(STEP_W)) u_step (
    .clk(clk), .rst_n(rst_n), .clear(clear), .restart(restart),
    .advance(advance), .step_q(step_q)
  );

  seqcmd_lock u_lock (
    .clk(clk), .rst_n(rst_n), .fire_store(fire_store), .fire_recall(fire_recall),
    .done(done), .store_cmd(store_cmd), .recall_cmd(recall_cmd), .busy(io_dis)
  );
endmodule

// File: rtl/seqcmd_detect_chk.sv
module seqcmd_detect_chk #(
  parameter int STEP_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_vld,
  input logic              wr_vld,
  input logic              done,
  input logic              store_cmd,
  input logic              recall_cmd,
  input logic              io_dis,
  input logic [STEP_W-1:0] step_q
);
  localparam int LAST = seqcmd_pkg::PREFIX_LEN;

  a_r1_step_range: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= STEP_W'(LAST));

  a_r2_store_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    store_cmd |=> !store_cmd);

  a_r3_recall_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    recall_cmd |=> !recall_cmd);

  a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_cmd && recall_cmd));

  a_r5_write_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_dis && wr_vld) |=> (step_q == '0 && !store_cmd && !recall_cmd));

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_vld && !wr_vld) |=> $stable(step_q));

  a_r8_disable_with_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (store_cmd || recall_cmd) |-> io_dis);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (io_dis && !done) |=> io_dis);

  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (io_dis && done) |=> !io_dis);

  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    io_dis |=> ($stable(step_q) && !store_cmd && !recall_cmd));

  a_r10_final_leaves: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_dis && rd_vld && !wr_vld && step_q == STEP_W'(LAST)) |=> step_q <= STEP_W'(1));

  a_r11_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_dis && done && !store_cmd) |=> (!io_dis || $past(rd_vld)));
endmodule

bind seqcmd_detect seqcmd_detect_chk #(.STEP_W(STEP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_vld(rd_vld), .wr_vld(wr_vld), .done(done),
  .store_cmd(store_cmd), .recall_cmd(recall_cmd), .io_dis(io_dis), .step_q(step_q)
);

// File: tb/seqcmd_detect_tb.sv
module seqcmd_detect_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic rd_vld = 1'b0, wr_vld = 1'b0, done = 1'b0;
  logic store_cmd, recall_cmd, io_dis;
  int errors = 0, checks = 0;

  localparam logic [15:0] K0 = 16'h4E38, K1 = 16'hB1C7, K2 = 16'h83E0,
                          K3 = 16'h7C1F, K4 = 16'h703F;
  localparam logic [15:0] SAVE = 16'h8FC0, LOAD = 16'h4C63;

  always #4 clk = ~clk;

  seqcmd_detect #(.ADDR_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_vld(rd_vld), .wr_vld(wr_vld),
    .done(done), .store_cmd(store_cmd), .recall_cmd(recall_cmd), .io_dis(io_dis)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  // Each access: driven at a falling edge, taken at the next rising edge,
  // strobes dropped at the following falling edge (where results are visible).
  task automatic rd(input logic [15:0] a);
    addr = a; rd_vld = 1'b1;
    @(negedge clk); rd_vld = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a);
    addr = a; wr_vld = 1'b1;
    @(negedge clk); wr_vld = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin addr = 16'h5A5A ^ 16'(i); @(negedge clk); end
  endtask

  task automatic pulse_done();
    done = 1'b1; @(negedge clk); done = 1'b0;
  endtask

  task automatic prefix();
    rd(K0); rd(K1); rd(K2); rd(K3); rd(K4);
  endtask

  task automatic expect_none(input string req);
    chk({req, " store"}, store_cmd, 1'b0);
    chk({req, " recall"}, recall_cmd, 1'b0);
    chk({req, " io_dis"}, io_dis, 1'b0);
  endtask

  task automatic t_reset();
    expect_none("R1");
  endtask

  task automatic t_store();
    prefix(); rd(SAVE);
    chk("R2 store pulse", store_cmd, 1'b1);
    chk("R2 no recall", recall_cmd, 1'b0);
    chk("R8 io_dis with pulse", io_dis, 1'b1);
    idle(1);
    chk("R2 pulse one cycle", store_cmd, 1'b0);
    idle(3);
    chk("R8 io_dis held", io_dis, 1'b1);
    pulse_done();
    chk("R8 io_dis released", io_dis, 1'b0);
  endtask

  task automatic t_recall();
    prefix(); rd(LOAD);
    chk("R3 recall pulse", recall_cmd, 1'b1);
    chk("R3 no store", store_cmd, 1'b0);
    idle(1);
    chk("R3 pulse one cycle", recall_cmd, 1'b0);
    pulse_done();
    expect_none("R3 after done");
  endtask

  task automatic t_gaps();
    rd(K0); idle(2); rd(K1); idle(1); rd(K2); rd(K3); idle(4); rd(K4); idle(1);
    rd(SAVE);
    chk("R6 gaps keep progress", store_cmd, 1'b1);
    pulse_done();
  endtask

  task automatic t_bad_read();
    rd(K0); rd(K1); rd(K2); rd(16'h1234); rd(K3); rd(K4); rd(SAVE);
    expect_none("R4 abort on wrong read");
    prefix(); rd(K1); rd(LOAD);
    expect_none("R4 repeated key aborts");
  endtask

  task automatic t_write();
    rd(K0); rd(K1); wr(K2); rd(K2); rd(K3); rd(K4); rd(SAVE);
    expect_none("R5 write to expected key");
    prefix(); wr(SAVE);
    expect_none("R5 write at final step");
    rd(K0); rd(K1);
    addr = K2; rd_vld = 1'b1; wr_vld = 1'b1; @(negedge clk); rd_vld = 1'b0; wr_vld = 1'b0;
    rd(K3); rd(K4); rd(SAVE);
    expect_none("R5 read and write together");
  endtask

  task automatic t_restart();
    rd(K0); rd(K1); rd(K2); rd(K0); rd(K1); rd(K2); rd(K3); rd(K4); rd(SAVE);
    chk("R7 restart mid prefix", store_cmd, 1'b1);
    pulse_done();
    prefix(); rd(K0); rd(K1); rd(K2); rd(K3); rd(K4); rd(LOAD);
    chk("R7 restart at final step", recall_cmd, 1'b1);
    pulse_done();
  endtask

  task automatic t_sixth_other();
    prefix(); rd(16'h8FC1);
    expect_none("R10 unknown final address");
    rd(SAVE);
    expect_none("R10 no resume after final abort");
  endtask

  task automatic t_busy();
    prefix(); rd(SAVE);
    chk("R9 command issued", store_cmd, 1'b1);
    prefix(); rd(LOAD); wr(16'h0001);
    chk("R9 no recall while busy", recall_cmd, 1'b0);
    chk("R9 io_dis stays", io_dis, 1'b1);
    prefix();
    pulse_done();
    rd(LOAD);
    expect_none("R9 busy reads not counted");
  endtask

  task automatic t_done_idle();
    pulse_done();
    expect_none("R11 done when idle");
    rd(K0); rd(K1); pulse_done(); rd(K2); rd(K3); rd(K4); rd(SAVE);
    chk("R11 progress kept across done", store_cmd, 1'b1);
    pulse_done();
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_store();
    t_recall();
    t_gaps();
    t_bad_read();
    t_write();
    t_restart();
    t_sixth_other();
    t_busy();
    t_done_idle();
    idle(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule